// File: doc/BRIEF.md
# Register-extension prefix state unit

This unit sits in an in-order decode stage and widens the 5-bit register fields of ordinary instructions so that they can reach a 256-entry floating-point register file. A dedicated prefix instruction carries a 32-bit payload that holds two slot groups. Each group supplies the upper three bits of the destination and of the three source register numbers, together with a SIMD flag. The unit stores these slots and hands them, in order, to the one or two instructions that follow the prefix. A slot becomes invalid as soon as its instruction issues.

The slot valid bits are kept as a four-state machine. The states are `S_EMPTY` (no slot armed), `S_BOTH` (both slots armed), `S_FIRST` (only the first slot armed) and `S_SECOND` (only the second slot armed). The transitions are:
- LOAD: a prefix issues. The next state is chosen from the payload valid bits.
- TAKE_FIRST: an ordinary instruction issues while the first slot is armed. `S_BOTH` moves to `S_SECOND`, and `S_FIRST` moves to `S_EMPTY`.
- TAKE_SECOND: an ordinary instruction issues in `S_SECOND`. The state moves to `S_EMPTY`.
- FLUSH: a flush occurs. Every state moves to `S_EMPTY`, and FLUSH has priority over the other transitions.

The register-number outputs are combinational and apply to the instruction currently presented. The state changes at the clock edge on which the instruction issues.

Top module: `regext_prefix_unit`

## Requirements
- R1: After reset, and whenever no slot is armed, an ordinary instruction gets upper bits 000 on all four register numbers. In that case `simd_out` is 0 and `ext_applied` is 0.
- R2: Bits 4:0 of each register number always equal the instruction's own 5-bit field. All outputs are zero when `instr_valid` is 0.
- R3: Each 16-bit slot group is laid out from its most significant bit down as follows: valid (1 bit), rd upper (3 bits), rs1 upper (3 bits), rs2 upper (3 bits), rs3 upper (3 bits), simd (1 bit), reserved (2 bits). The first slot is `prefix_word[31:16]` and the second slot is `prefix_word[15:0]`. An upper field forms bits 7:5 of its register number.
- R4: The first ordinary instruction that issues after a prefix with an armed first slot takes that slot's fields. `ext_applied` is 1 for that instruction.
- R5: When `prefix_two`=1, the second ordinary instruction takes the second slot's fields. The third ordinary instruction gets the default of R1.
- R6: When `prefix_two`=0, only the first slot is armed. The second slot is treated as unarmed even if its payload valid bit is 1.
- R7: If the first slot is not armed but the second slot is, the next ordinary instruction takes the second slot.
- R8: A slot is consumed only when `instr_valid` and `instr_issue` are both 1. A stalled instruction sees the slot but leaves it armed. A stalled prefix loads nothing.
- R9: A prefix that issues while slots are still armed replaces both slots with its own payload.
- R10: `flush` disarms both slots at the next edge. It takes priority over a prefix or a consuming instruction issued in the same cycle. The instruction presented in the flush cycle still sees the old slot.
- R11: A presented prefix drives all register numbers to zero, `simd_out` to 0 and `ext_applied` to 0. It never consumes a slot.
- R12: The two reserved bits of each slot group have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush; disarms both slots |
| instr_valid | input | 1 | An instruction is presented |
| instr_issue | input | 1 | The presented instruction issues this cycle |
| is_prefix | input | 1 | The presented instruction is the extension prefix |
| prefix_two | input | 1 | Prefix variant: 1 covers two instructions, 0 covers one |
| prefix_word | input | 32 | Prefix payload (two slot groups) |
| rd_lo | input | 5 | Instruction destination field |
| rs1_lo | input | 5 | Instruction source-1 field |
| rs2_lo | input | 5 | Instruction source-2 field |
| rs3_lo | input | 5 | Instruction source-3 field |
| rd_num | output | 8 | Widened destination register number |
| rs1_num | output | 8 | Widened source-1 register number |
| rs2_num | output | 8 | Widened source-2 register number |
| rs3_num | output | 8 | Widened source-3 register number |
| simd_out | output | 1 | SIMD flag for the presented instruction |
| ext_applied | output | 1 | A slot supplied the upper bits |

## Verification
The bench targets the following corner cases, and each one catches a specific kind of design error:
- A stalled instruction is shown before it issues. A design that consumes a slot without the issue strobe would hand the second slot to the real issue.
- A one-instruction prefix carries a second group whose payload valid bit is set. A design that forgets to clear that slot would extend a third instruction.
- A prefix has its first slot unarmed. A design without the fallback rule would give the next instruction zero upper bits instead of the second slot.
- A prefix overwrites pending slots, and a flush coincides first with a consuming instruction and then with a prefix. A design with the wrong priority leaves a stale or freshly loaded slot that then shows up on the following instruction.

// File: rtl/regext_pkg.sv
package regext_pkg;
    parameter int LO_W   = 5;
    parameter int HI_W   = 3;
    parameter int REG_W  = LO_W + HI_W;
    parameter int NFIELD = 4;
    parameter int WORD_W = 32;
    parameter int HALF_W = WORD_W / 2;

    typedef struct packed {
        logic            valid;
        logic [HI_W-1:0] rd;
        logic [HI_W-1:0] rs1;
        logic [HI_W-1:0] rs2;
        logic [HI_W-1:0] rs3;
        logic            simd;
    } slot_t;

    parameter int SLOT_W = $bits(slot_t);
    parameter int RSV_W  = HALF_W - SLOT_W;

    typedef enum logic [1:0] {
        S_EMPTY  = 2'd0,
        S_FIRST  = 2'd1,
        S_SECOND = 2'd2,
        S_BOTH   = 2'd3
    } slot_state_t;
endpackage

// File: rtl/regext_slot_unpack.sv
module regext_slot_unpack
    import regext_pkg::*;
(
    input  logic [HALF_W-1:0] half_word,
    output slot_t             slot
);
    logic [RSV_W-1:0] rsv_unused;

    assign slot       = half_word[HALF_W-1 -: SLOT_W];
    assign rsv_unused = half_word[RSV_W-1:0];
endmodule

// File: rtl/regext_widen.sv
module regext_widen
    import regext_pkg::*;
(
    input  logic                         en,
    input  logic [NFIELD-1:0][LO_W-1:0]  lo_fields,
    input  logic [NFIELD-1:0][HI_W-1:0]  hi_fields,
    output logic [NFIELD-1:0][REG_W-1:0] reg_nums
);
    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        assign reg_nums[g] = en ? {hi_fields[g], lo_fields[g]} : '0;
    end
endmodule

// File: rtl/regext_seq_fsm.sv
module regext_seq_fsm
    import regext_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic pfx_fire,
    input  logic use_fire,
    input  logic new_first,
    input  logic new_second,
    output logic sel_first,
    output logic sel_second
);
    slot_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = S_EMPTY;                       // FLUSH
        end else if (pfx_fire) begin                 // LOAD
            unique case ({new_first, new_second})
                2'b11:   state_d = S_BOTH;
                2'b10:   state_d = S_FIRST;
                2'b01:   state_d = S_SECOND;
                default: state_d = S_EMPTY;
            endcase
        end else if (use_fire) begin
            unique case (state_q)
                S_BOTH:   state_d = S_SECOND;        // TAKE_FIRST
                S_FIRST:  state_d = S_EMPTY;         // TAKE_FIRST
                S_SECOND: state_d = S_EMPTY;         // TAKE_SECOND
                default:  state_d = S_EMPTY;
            endcase
        end
    end

    always_comb begin
        sel_first  = 1'b0;
        sel_second = 1'b0;
        unique case (state_q)
            S_BOTH,
            S_FIRST:  sel_first  = 1'b1;
            S_SECOND: sel_second = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/regext_prefix_unit.sv
module regext_prefix_unit
    import regext_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              instr_valid,
    input  logic              instr_issue,
    input  logic              is_prefix,
    input  logic              prefix_two,
    input  logic [WORD_W-1:0] prefix_word,
    input  logic [LO_W-1:0]   rd_lo,
    input  logic [LO_W-1:0]   rs1_lo,
    input  logic [LO_W-1:0]   rs2_lo,
    input  logic [LO_W-1:0]   rs3_lo,
    output logic [REG_W-1:0]  rd_num,
    output logic [REG_W-1:0]  rs1_num,
    output logic [REG_W-1:0]  rs2_num,
    output logic [REG_W-1:0]  rs3_num,
    output logic              simd_out,
    output logic              ext_applied
);
    logic  fire, pfx_fire, use_fire, active;
    logic  sel_first, sel_second;
    slot_t new_slot [2];
    slot_t slot_q   [2];
    slot_t cur_slot;
    logic [NFIELD-1:0][LO_W-1:0]  lo_vec;
    logic [NFIELD-1:0][HI_W-1:0]  hi_vec;
    logic [NFIELD-1:0][REG_W-1:0] num_vec;

    assign fire     = instr_valid && instr_issue;
    assign pfx_fire = fire && is_prefix;
    assign use_fire = fire && !is_prefix;
    assign active   = instr_valid && !is_prefix;

    for (genvar s = 0; s < 2; s++) begin : g_slot
        regext_slot_unpack u_unpack (
            .half_word (prefix_word[WORD_W-1-s*HALF_W -: HALF_W]),
            .slot      (new_slot[s])
        );

        always_ff @(posedge clk) begin
            if (!rst_n)                 slot_q[s] <= '0;
            else if (pfx_fire && !flush) slot_q[s] <= new_slot[s];
        end
    end

    regext_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .pfx_fire   (pfx_fire),
        .use_fire   (use_fire),
        .new_first  (new_slot[0].valid),
        .new_second (prefix_two && new_slot[1].valid),
        .sel_first  (sel_first),
        .sel_second (sel_second)
    );

    always_comb begin
        if (sel_first)       cur_slot = slot_q[0];
        else if (sel_second) cur_slot = slot_q[1];
        else                 cur_slot = '0;
    end

    assign lo_vec = {rs3_lo, rs2_lo, rs1_lo, rd_lo};
    assign hi_vec = {cur_slot.rs3, cur_slot.rs2, cur_slot.rs1, cur_slot.rd};

    regext_widen u_widen (
        .en        (active),
        .lo_fields (lo_vec),
        .hi_fields (hi_vec),
        .reg_nums  (num_vec)
    );

    assign rd_num      = num_vec[0];
    assign rs1_num     = num_vec[1];
    assign rs2_num     = num_vec[2];
    assign rs3_num     = num_vec[3];
    assign simd_out    = active && cur_slot.simd;
    assign ext_applied = active && (sel_first || sel_second);
endmodule

// File: rtl/regext_prefix_unit_chk.sv
module regext_prefix_unit_chk
    import regext_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              instr_valid,
    input logic              instr_issue,
    input logic              is_prefix,
    input logic              prefix_two,
    input logic [WORD_W-1:0] prefix_word,
    input logic [LO_W-1:0]   rd_lo,
    input logic [LO_W-1:0]   rs1_lo,
    input logic [LO_W-1:0]   rs2_lo,
    input logic [LO_W-1:0]   rs3_lo,
    input logic [REG_W-1:0]  rd_num,
    input logic [REG_W-1:0]  rs1_num,
    input logic [REG_W-1:0]  rs2_num,
    input logic [REG_W-1:0]  rs3_num,
    input logic              simd_out,
    input logic              ext_applied
);
    p_prefix_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && is_prefix) |-> (!ext_applied && !simd_out &&
            rd_num == '0 && rs1_num == '0 && rs2_num == '0 && rs3_num == '0));

    p_low_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !is_prefix) |-> (rd_num[LO_W-1:0] == rd_lo &&
            rs1_num[LO_W-1:0] == rs1_lo && rs2_num[LO_W-1:0] == rs2_lo &&
            rs3_num[LO_W-1:0] == rs3_lo));

    p_default_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_applied |-> (!simd_out && rd_num[REG_W-1:LO_W] == '0 &&
            rs1_num[REG_W-1:LO_W] == '0 && rs2_num[REG_W-1:LO_W] == '0 &&
            rs3_num[REG_W-1:LO_W] == '0));

    p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !ext_applied);

    p_load_arms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_issue && is_prefix && !flush) |=>
            (!(instr_valid && !is_prefix) ||
             ext_applied == ($past(prefix_word[WORD_W-1]) ||
                             ($past(prefix_two) && $past(prefix_word[HALF_W-1])))));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !instr_issue && !flush && ext_applied) |=>
            (!(instr_valid && !is_prefix) || ext_applied));
endmodule

bind regext_prefix_unit regext_prefix_unit_chk u_chk (.*);

// File: tb/regext_prefix_unit_bench.sv
module regext_prefix_unit_bench;
    localparam int CYC = 8;

    typedef struct packed {
        logic        fl, vl, is, px, tw;
        logic [31:0] word;
        logic [4:0]  lo;
        logic [11:0] up;
        logic        simd, app;
        logic [3:0]  req;
    } step_t;

    function automatic logic [15:0] half(input logic v, input logic [2:0] a,
        input logic [2:0] b, input logic [2:0] c, input logic [2:0] d,
        input logic s, input logic [1:0] r);
        return {v, a, b, c, d, s, r};
    endfunction

    function automatic step_t row(input logic fl, input logic vl, input logic is,
        input logic px, input logic tw, input logic [31:0] word, input logic [4:0] lo,
        input logic [11:0] up, input logic simd, input logic app, input logic [3:0] req);
        return '{fl, vl, is, px, tw, word, lo, up, simd, app, req};
    endfunction

    localparam int N = 28;
    localparam step_t TBL [N] = '{
        row(0,1,1,0,0,32'h0,5,12'o0000,0,0,1),                                      // R1
        row(0,1,1,1,1,{half(1,1,2,3,4,1,3),half(1,7,6,5,4,0,0)},0,0,0,0,11),        // R11 R12
        row(0,1,0,0,0,32'h0,9,12'o1234,1,1,8),                                      // R8 stall
        row(0,1,1,0,0,32'h0,9,12'o1234,1,1,4),                                      // R4
        row(0,1,1,0,0,32'h0,31,12'o7654,0,1,5),                                     // R5
        row(0,1,1,0,0,32'h0,0,12'o0000,0,0,5),                                      // R5
        row(0,1,1,1,0,{half(1,2,2,2,2,0,0),half(1,5,5,5,5,1,0)},0,0,0,0,6),         // R6
        row(0,1,1,0,0,32'h0,3,12'o2222,0,1,6),                                      // R6
        row(0,1,1,0,0,32'h0,3,12'o0000,0,0,6),                                      // R6
        row(0,1,1,1,1,{half(0,3,3,3,3,1,0),half(1,1,1,1,1,1,2)},0,0,0,0,7),         // R7
        row(0,1,1,0,0,32'h0,17,12'o1111,1,1,7),                                     // R7
        row(0,1,1,0,0,32'h0,17,12'o0000,0,0,7),                                     // R7
        row(0,1,1,1,1,{half(1,6,6,6,6,0,0),half(1,5,5,5,5,0,0)},0,0,0,0,9),         // R9
        row(0,1,1,1,1,{half(1,3,2,1,0,1,0),half(1,4,4,4,4,0,0)},0,0,0,0,9),         // R9
        row(0,1,1,0,0,32'h0,12,12'o3210,1,1,9),                                     // R9
        row(0,1,1,0,0,32'h0,12,12'o4444,0,1,9),                                     // R9
        row(0,1,1,0,0,32'h0,12,12'o0000,0,0,9),                                     // R9
        row(0,1,1,1,1,{half(1,1,1,1,1,0,0),half(1,2,2,2,2,0,0)},0,0,0,0,10),        // R10
        row(1,1,1,0,0,32'h0,20,12'o1111,0,1,10),                                    // R10
        row(0,1,1,0,0,32'h0,20,12'o0000,0,0,10),                                    // R10
        row(1,1,1,1,1,{half(1,7,7,7,7,1,0),half(1,7,7,7,7,1,0)},0,0,0,0,10),        // R10
        row(0,1,1,0,0,32'h0,21,12'o0000,0,0,10),                                    // R10
        row(0,1,0,1,1,{half(1,5,5,5,5,1,0),half(1,5,5,5,5,1,0)},0,0,0,0,8),         // R8
        row(0,1,1,0,0,32'h0,22,12'o0000,0,0,8),                                     // R8
        row(0,0,1,0,0,32'h0,22,12'o0000,0,0,2),                                     // R2
        row(0,1,1,1,1,{half(1,1,2,1,2,0,0),half(0,7,7,7,7,1,0)},0,0,0,0,3),         // R3
        row(0,1,1,0,0,32'h0,13,12'o1212,0,1,3),                                     // R3
        row(0,1,1,0,0,32'h0,13,12'o0000,0,0,3)                                      // R3
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        flush = 0, instr_valid = 0, instr_issue = 0, is_prefix = 0, prefix_two = 0;
    logic [31:0] prefix_word = '0;
    logic [4:0]  rd_lo = '0, rs1_lo = '0, rs2_lo = '0, rs3_lo = '0;
    logic [7:0]  rd_num, rs1_num, rs2_num, rs3_num;
    logic        simd_out, ext_applied;
    int          total = 0, bad = 0;
    bit          done = 0;

    always #(CYC/2) clk = ~clk;

    regext_prefix_unit u_regext_prefix_unit (.*);

    task automatic drive(input step_t s);
        flush = s.fl; instr_valid = s.vl; instr_issue = s.is;
        is_prefix = s.px; prefix_two = s.tw; prefix_word = s.word;
        rd_lo = s.lo; rs1_lo = s.lo ^ 5'd1; rs2_lo = s.lo ^ 5'd2; rs3_lo = s.lo ^ 5'd3;
    endtask

    task automatic check(input step_t s);
        logic [33:0] act, exp;
        logic [31:0] nums;
        if (s.vl && !s.px)
            nums = {s.up[11:9], s.lo, s.up[8:6], s.lo ^ 5'd1,
                    s.up[5:3], s.lo ^ 5'd2, s.up[2:0], s.lo ^ 5'd3};
        else
            nums = '0;
        exp = {nums, s.simd, s.app};
        act = {rd_num, rs1_num, rs2_num, rs3_num, simd_out, ext_applied};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d: actual=%h expected=%h", s.req, act, exp);
        end
    endtask

    initial begin
        #(CYC*20000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step_t s;
        repeat (3) @(negedge clk);
        // R1: outputs during reset with an ordinary instruction
        drive(TBL[0]);
        #2 check(TBL[0]);
        @(negedge clk) rst_n = 1;
        for (int i = 0; i < N; i++) begin
            drive(TBL[i]);
            #2 check(TBL[i]);
            @(negedge clk);
        end
        // R1: reset discards armed slots
        s = row(0,1,1,1,1,{half(1,7,7,7,7,1,0),half(1,7,7,7,7,1,0)},0,0,0,0,1);
        drive(s);
        #2 check(s);
        @(negedge clk) rst_n = 0;
        s = row(0,0,0,0,0,32'h0,0,0,0,0,1);
        drive(s);
        @(negedge clk) rst_n = 1;
        s = row(0,1,1,0,0,32'h0,27,12'o0000,0,0,1);
        drive(s);
        #2 check(s);
        @(negedge clk);
        // R2: low fields pass with all-ones lower bits and armed slot
        s = row(0,1,1,1,0,{half(1,5,4,3,2,1,3),half(0,0,0,0,0,0,3)},0,0,0,0,2);
        drive(s);
        #2 check(s);
        @(negedge clk);
        s = row(0,1,1,0,0,32'h0,31,12'o5432,1,1,2);
        drive(s);
        #2 check(s);
        @(negedge clk);
        drive(row(0,0,0,0,0,32'h0,0,0,0,0,2));
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule